// File: doc/BRIEF.md
# I2C Interface Control and Mode Register

This block is the CPU-facing control register of an I2C bus interface. It stores the interface enable, the interrupt enable and the two mode bits that choose between slave receive, slave transmit, master receive and master transmit. The bit-level shift engine, the START/STOP logic and the clock generator sit outside. They report to this block through single-cycle event strobes (arbitration lost, transfer complete, address byte received) and through requests to pull SCL or SDA low.

The block owns the state that hardware may change behind the CPU's back. Losing arbitration as a master drops the mode to slave receive. A matching address byte in slave receive mode picks slave transmit or slave receive from its R/W bit. One register address is shared: while the interface is off it reaches the own-address register, and while it is on it reaches the mode-data register. The block gates the bus output enables with the enable bit. SDA is also gated by an expanded-bus input, because in that mode the pin belongs to a WAIT function. The interrupt line is a pending flag masked by the interrupt enable.

Top module: `i2c_ctl_mode`

## Requirements
- R1: While the enable bit (control bit 0) is 0, `scl_oe` and `sda_oe` are 0. While it is 1, `scl_oe` follows `scl_pull` and `sda_oe` follows `sda_pull`.
- R2: Accesses to SHARED_ADDR (default 1) reach the own-address register while the enable bit is 0, and the mode-data register while it is 1. A write through one of them leaves the other unchanged.
- R3: `irq` is 1 exactly when the interrupt-enable bit (control bit 1) is 1 and the pending flag is set.
- R4: The control register at CTRL_ADDR (default 0) reads as {4'b0, MST (bit 3), TRS (bit 2), IE (bit 1), EN (bit 0)}. {MST,TRS} encodes 00 slave receive, 01 slave transmit, 10 master receive and 11 master transmit. Write data bits 7:4 are ignored. A write is visible in the cycle after its clock edge.
- R5: After reset, the control register, the own-address register, the mode-data register and the pending flag are all 0, so the block starts disabled in slave receive mode.
- R6: An arbitration-lost strobe while enabled in a master mode sets {MST,TRS} to 00 on the next edge. The same strobe in a slave mode leaves the mode unchanged.
- R7: The own-address register holds a 7-bit address in bits 7:1 and a format bit in bit 0, where 0 selects the addressing format. An address-byte strobe while enabled, in slave receive, with format 0 and `rx_byte[7:1]` equal to the own address, sets TRS to `rx_byte[0]`. A mismatch, a set format bit or any other mode leaves the mode unchanged.
- R8: While `ext_mode` is 1, `sda_oe` is 0 whatever `sda_pull` is. `scl_oe` is unaffected.
- R9: When a CPU control write and a hardware mode override land in the same cycle, the override decides MST and TRS. EN and IE still take the written values.
- R10: The pending flag, read at STAT_ADDR (default 2) bit 0, is set by an arbitration-lost or transfer-complete strobe while enabled. It is cleared by writing 1 to that bit. A set in the same cycle as a clear wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |
| evt_arb_lost | input | 1 | Arbitration lost strobe from the shift engine |
| evt_xfer_done | input | 1 | Transfer complete strobe |
| evt_addr_rx | input | 1 | First byte after START received |
| rx_byte | input | 8 | Received byte that accompanies evt_addr_rx |
| ext_mode | input | 1 | Expanded bus mode; WAIT owns the SDA pin |
| scl_pull | input | 1 | Engine request to pull SCL low |
| sda_pull | input | 1 | Engine request to pull SDA low |
| scl_oe | output | 1 | SCL output enable |
| sda_oe | output | 1 | SDA output enable |
| irq | output | 1 | Interrupt request to the CPU |

## Verification
The hardest case to reach from the ports is a CPU control write that collides with a hardware override in the same clock. It needs the write strobe and an event strobe raised together, from a state that the write itself is trying to leave. The bench has one stimulus task that drives a write and any set of event strobes in a single cycle. It first places the block in master transmit, or in slave receive with a known own address, and then issues the colliding write with arbitration loss or a matching address byte. The pending-flag set/clear collision is reached the same way.

// File: rtl/i2c_ctl_pkg.sv
package i2c_ctl_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        MODE_SRX = 2'b00,
        MODE_STX = 2'b01,
        MODE_MRX = 2'b10,
        MODE_MTX = 2'b11
    } mode_e;

    typedef struct packed {
        mode_e mode;
        logic  ie;
        logic  en;
    } ctrl_t;

    typedef struct packed {
        ctrl_t             ctrl;
        logic [BYTE_W-1:0] own;
        logic [BYTE_W-1:0] mdr;
    } regs_t;
endpackage

// File: rtl/i2c_ctl_decode.sv
module i2c_ctl_decode
    import i2c_ctl_pkg::*;
#(
    parameter int                ADDR_W      = 2,
    parameter logic [ADDR_W-1:0] CTRL_ADDR   = 0,
    parameter logic [ADDR_W-1:0] SHARED_ADDR = 1,
    parameter logic [ADDR_W-1:0] STAT_ADDR   = 2
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  ctrl_t             ctrl,
    input  logic [BYTE_W-1:0] own,
    input  logic [BYTE_W-1:0] mdr,
    input  logic              pend,
    output logic              wr_ctrl,
    output logic              wr_own,
    output logic              wr_mdr,
    output logic              wr_stat,
    output logic [BYTE_W-1:0] rdata
);
    always_comb begin
        wr_ctrl = wr && (addr == CTRL_ADDR);
        wr_own  = wr && (addr == SHARED_ADDR) && !ctrl.en;
        wr_mdr  = wr && (addr == SHARED_ADDR) && ctrl.en;
        wr_stat = wr && (addr == STAT_ADDR);
        rdata   = '0;
        if (addr == CTRL_ADDR) begin
            rdata[3:0] = ctrl;
        end else if (addr == SHARED_ADDR) begin
            rdata = ctrl.en ? mdr : own;
        end else if (addr == STAT_ADDR) begin
            rdata[0] = pend;
        end
    end
endmodule

// File: rtl/i2c_ctl_hwmode.sv
module i2c_ctl_hwmode
    import i2c_ctl_pkg::*;
(
    input  logic              en,
    input  mode_e             cur,
    input  logic [BYTE_W-1:0] own,
    input  logic              sw_wr,
    input  mode_e             sw_mode,
    input  logic              arb_lost,
    input  logic              addr_rx,
    input  logic [BYTE_W-1:0] rx_byte,
    output mode_e             nxt
);
    logic is_master;
    logic arb_hit;
    logic addr_hit;

    always_comb begin
        is_master = (cur == MODE_MRX) || (cur == MODE_MTX);
        arb_hit   = en && is_master && arb_lost;
        addr_hit  = en && (cur == MODE_SRX) && !own[0] && addr_rx &&
                    (rx_byte[BYTE_W-1:1] == own[BYTE_W-1:1]);
        if (arb_hit) begin
            nxt = MODE_SRX;
        end else if (addr_hit) begin
            nxt = rx_byte[0] ? MODE_STX : MODE_SRX;
        end else if (sw_wr) begin
            nxt = sw_mode;
        end else begin
            nxt = cur;
        end
    end
endmodule

// File: rtl/i2c_ctl_pend.sv
module i2c_ctl_pend (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic set_arb,
    input  logic set_done,
    input  logic clr,
    output logic pend
);
    logic pend_d, pend_q;

    always_comb begin
        pend_d = pend_q;
        if (clr) pend_d = 1'b0;
        if (en && (set_arb || set_done)) pend_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend_q <= 1'b0;
        else        pend_q <= pend_d;
    end

    assign pend = pend_q;
endmodule

// File: rtl/i2c_ctl_mode.sv
module i2c_ctl_mode
    import i2c_ctl_pkg::*;
#(
    parameter int                ADDR_W      = 2,
    parameter logic [ADDR_W-1:0] CTRL_ADDR   = 0,
    parameter logic [ADDR_W-1:0] SHARED_ADDR = 1,
    parameter logic [ADDR_W-1:0] STAT_ADDR   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    input  logic              evt_arb_lost,
    input  logic              evt_xfer_done,
    input  logic              evt_addr_rx,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic              ext_mode,
    input  logic              scl_pull,
    input  logic              sda_pull,
    output logic              scl_oe,
    output logic              sda_oe,
    output logic              irq
);
    regs_t regs_d, regs_q;
    logic  wr_ctrl, wr_own, wr_mdr, wr_stat;
    logic  pend_q;
    mode_e mode_nxt;

    logic  en_q, ie_q;
    mode_e mode_q;
    assign en_q   = regs_q.ctrl.en;
    assign ie_q   = regs_q.ctrl.ie;
    assign mode_q = regs_q.ctrl.mode;

    i2c_ctl_decode #(
        .ADDR_W     (ADDR_W),
        .CTRL_ADDR  (CTRL_ADDR),
        .SHARED_ADDR(SHARED_ADDR),
        .STAT_ADDR  (STAT_ADDR)
    ) u_decode (
        .addr   (bus_addr),
        .wr     (bus_wr),
        .ctrl   (regs_q.ctrl),
        .own    (regs_q.own),
        .mdr    (regs_q.mdr),
        .pend   (pend_q),
        .wr_ctrl(wr_ctrl),
        .wr_own (wr_own),
        .wr_mdr (wr_mdr),
        .wr_stat(wr_stat),
        .rdata  (bus_rdata)
    );

    i2c_ctl_hwmode u_hwmode (
        .en      (en_q),
        .cur     (mode_q),
        .own     (regs_q.own),
        .sw_wr   (wr_ctrl),
        .sw_mode (mode_e'(bus_wdata[3:2])),
        .arb_lost(evt_arb_lost),
        .addr_rx (evt_addr_rx),
        .rx_byte (rx_byte),
        .nxt     (mode_nxt)
    );

    i2c_ctl_pend u_pend (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (en_q),
        .set_arb (evt_arb_lost),
        .set_done(evt_xfer_done),
        .clr     (wr_stat && bus_wdata[0]),
        .pend    (pend_q)
    );

    always_comb begin
        regs_d           = regs_q;
        regs_d.ctrl.mode = mode_nxt;
        if (wr_ctrl) begin
            regs_d.ctrl.en = bus_wdata[0];
            regs_d.ctrl.ie = bus_wdata[1];
        end
        if (wr_own) regs_d.own = bus_wdata;
        if (wr_mdr) regs_d.mdr = bus_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign scl_oe = en_q && scl_pull;
    assign sda_oe = en_q && !ext_mode && sda_pull;
    assign irq    = ie_q && pend_q;
endmodule

// File: rtl/i2c_ctl_mode_chk.sv
module i2c_ctl_mode_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       en_q,
    input logic       ie_q,
    input logic [1:0] mode_q,
    input logic [7:0] own_q,
    input logic       pend_q,
    input logic       evt_arb_lost,
    input logic       evt_xfer_done,
    input logic       evt_addr_rx,
    input logic [7:0] rx_byte,
    input logic       ext_mode,
    input logic       scl_oe,
    input logic       sda_oe,
    input logic       irq
);
    // R1
    a_r1_pads_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q |-> (!scl_oe && !sda_oe));
    // R8
    a_r8_wait_owns_sda: assert property (@(posedge clk) disable iff (!rst_n)
        ext_mode |-> !sda_oe);
    // R3
    a_r3_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (ie_q && pend_q));
    // R6
    a_r6_arb_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q && mode_q[1] && evt_arb_lost) |=> (mode_q == 2'b00));
    // R7
    a_r7_addr_rw: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q && mode_q == 2'b00 && !own_q[0] && evt_addr_rx &&
         rx_byte[7:1] == own_q[7:1]) |=> (mode_q == {1'b0, $past(rx_byte[0])}));
    // R10
    a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q && (evt_xfer_done || evt_arb_lost)) |=> pend_q);
endmodule

bind i2c_ctl_mode i2c_ctl_mode_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .en_q         (en_q),
    .ie_q         (ie_q),
    .mode_q       (mode_q),
    .own_q        (regs_q.own),
    .pend_q       (pend_q),
    .evt_arb_lost (evt_arb_lost),
    .evt_xfer_done(evt_xfer_done),
    .evt_addr_rx  (evt_addr_rx),
    .rx_byte      (rx_byte),
    .ext_mode     (ext_mode),
    .scl_oe       (scl_oe),
    .sda_oe       (sda_oe),
    .irq          (irq)
);

// File: tb/i2c_ctl_mode_tb.sv
module i2c_ctl_mode_tb;
    localparam logic [1:0] A_CTRL = 2'd0;
    localparam logic [1:0] A_SHR  = 2'd1;
    localparam logic [1:0] A_STAT = 2'd2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       evt_arb_lost = 1'b0, evt_xfer_done = 1'b0, evt_addr_rx = 1'b0;
    logic [7:0] rx_byte = '0;
    logic       ext_mode = 1'b0, scl_pull = 1'b1, sda_pull = 1'b1;
    logic       scl_oe, sda_oe, irq;

    always #4 clk = ~clk;

    i2c_ctl_mode u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .evt_arb_lost(evt_arb_lost), .evt_xfer_done(evt_xfer_done),
        .evt_addr_rx(evt_addr_rx), .rx_byte(rx_byte), .ext_mode(ext_mode),
        .scl_pull(scl_pull), .sda_pull(sda_pull),
        .scl_oe(scl_oe), .sda_oe(sda_oe), .irq(irq)
    );

    typedef struct {
        bit         pins;
        logic [1:0] addr;
        logic [7:0] exp;
        string      tag;
    } item_t;

    item_t q[$];
    int    n_chk = 0;
    int    n_bad = 0;

    // monitor: compares each queued expectation at the falling edge
    always @(negedge clk) begin
        if (q.size() > 0) begin
            item_t it;
            logic [7:0] act;
            it  = q.pop_front();
            act = it.pins ? {5'b0, irq, sda_oe, scl_oe} : bus_rdata;
            n_chk++;
            if (act !== it.exp) begin
                n_bad++;
                $display("FAIL %s: actual %02h expected %02h", it.tag, act, it.exp);
            end
        end
    end

    task automatic cyc(input bit wr, input logic [1:0] a, input logic [7:0] d,
                       input bit arb, input bit done, input bit arx,
                       input logic [7:0] rb);
        @(posedge clk); #1;
        bus_wr = wr; bus_addr = a; bus_wdata = d;
        evt_arb_lost = arb; evt_xfer_done = done; evt_addr_rx = arx; rx_byte = rb;
        @(posedge clk); #1;
        bus_wr = 0; evt_arb_lost = 0; evt_xfer_done = 0; evt_addr_rx = 0;
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        cyc(1, a, d, 0, 0, 0, 8'h00);
    endtask

    task automatic exp_rd(input logic [1:0] a, input logic [7:0] e, input string tag);
        item_t it;
        bus_addr = a;
        it.pins = 0; it.addr = a; it.exp = e; it.tag = tag;
        q.push_back(it);
        @(negedge clk); #1;
    endtask

    task automatic exp_pins(input logic [2:0] e, input string tag);
        item_t it;
        it.pins = 1; it.addr = '0; it.exp = {5'b0, e}; it.tag = tag;
        q.push_back(it);
        @(negedge clk); #1;
    endtask

    bit finished = 0;

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R5 reset state
        exp_rd(A_CTRL, 8'h00, "R5 ctrl reset");
        exp_rd(A_SHR, 8'h00, "R5 own addr reset");
        exp_rd(A_STAT, 8'h00, "R5 pending reset");
        exp_pins(3'b000, "R1 pads off while disabled");
        // R2 own address while disabled
        wr(A_SHR, 8'hA4);
        exp_rd(A_SHR, 8'hA4, "R2 own addr write");
        wr(A_CTRL, 8'h01);
        exp_pins(3'b011, "R1 pads follow pulls when enabled");
        exp_rd(A_SHR, 8'h00, "R2 mode data visible when enabled");
        wr(A_SHR, 8'h3C);
        exp_rd(A_SHR, 8'h3C, "R2 mode data write");
        wr(A_CTRL, 8'h00);
        exp_rd(A_SHR, 8'hA4, "R2 own addr untouched");
        wr(A_CTRL, 8'h01);
        exp_rd(A_SHR, 8'h3C, "R2 mode data untouched");
        // R8
        ext_mode = 1'b1;
        exp_pins(3'b001, "R8 expanded mode blocks sda");
        ext_mode = 1'b0;
        sda_pull = 1'b0;
        exp_pins(3'b001, "R1 sda follows pull low request");
        sda_pull = 1'b1;
        // R4
        wr(A_CTRL, 8'h0F);
        exp_rd(A_CTRL, 8'h0F, "R4 master transmit readback");
        wr(A_CTRL, 8'hF5);
        exp_rd(A_CTRL, 8'h05, "R4 upper bits ignored");
        // R6 arbitration loss in master transmit, ie off
        wr(A_CTRL, 8'h0D);
        cyc(0, A_CTRL, 8'h00, 1, 0, 0, 8'h00);
        exp_rd(A_CTRL, 8'h01, "R6 arb loss drops to slave receive");
        exp_rd(A_STAT, 8'h01, "R10 arb loss sets pending");
        exp_pins(3'b011, "R3 irq masked with ie=0");
        wr(A_CTRL, 8'h03);
        exp_pins(3'b111, "R3 irq passes with ie=1");
        wr(A_STAT, 8'h01);
        exp_rd(A_STAT, 8'h00, "R10 write one clears pending");
        exp_pins(3'b011, "R3 irq drops after clear");
        // R6 arb strobe in slave transmit: no mode change
        wr(A_CTRL, 8'h07);
        cyc(0, A_CTRL, 8'h00, 1, 0, 0, 8'h00);
        exp_rd(A_CTRL, 8'h07, "R6 slave mode unaffected by arb");
        wr(A_STAT, 8'h01);
        // R7 address match
        wr(A_CTRL, 8'h03);
        cyc(0, A_CTRL, 8'h00, 0, 0, 1, 8'hA5);
        exp_rd(A_CTRL, 8'h07, "R7 match with read selects slave transmit");
        wr(A_CTRL, 8'h03);
        cyc(0, A_CTRL, 8'h00, 0, 0, 1, 8'hB5);
        exp_rd(A_CTRL, 8'h03, "R7 mismatch keeps mode");
        cyc(0, A_CTRL, 8'h00, 0, 0, 1, 8'hA4);
        exp_rd(A_CTRL, 8'h03, "R7 match with write keeps slave receive");
        wr(A_CTRL, 8'h0B);
        cyc(0, A_CTRL, 8'h00, 0, 0, 1, 8'hA5);
        exp_rd(A_CTRL, 8'h0B, "R7 master mode ignores address byte");
        wr(A_CTRL, 8'h00);
        wr(A_SHR, 8'hA5);
        wr(A_CTRL, 8'h03);
        cyc(0, A_CTRL, 8'h00, 0, 0, 1, 8'hA5);
        exp_rd(A_CTRL, 8'h03, "R7 format bit set ignores address byte");
        wr(A_CTRL, 8'h00);
        wr(A_SHR, 8'hA4);
        // R9 collisions
        wr(A_CTRL, 8'h0F);
        cyc(1, A_CTRL, 8'h0D, 1, 0, 0, 8'h00);
        exp_rd(A_CTRL, 8'h01, "R9 arb override beats write");
        wr(A_CTRL, 8'h03);
        cyc(1, A_CTRL, 8'h0B, 0, 0, 1, 8'hA5);
        exp_rd(A_CTRL, 8'h07, "R9 address override beats write");
        // R10 set beats clear
        exp_rd(A_STAT, 8'h01, "R10 pending from collision arb");
        cyc(1, A_STAT, 8'h01, 0, 1, 0, 8'h00);
        exp_rd(A_STAT, 8'h01, "R10 set wins over clear");
        wr(A_STAT, 8'h01);
        exp_rd(A_STAT, 8'h00, "R10 cleared");
        cyc(0, A_CTRL, 8'h00, 0, 1, 0, 8'h00);
        exp_rd(A_STAT, 8'h01, "R10 transfer done sets pending");
        repeat (2) @(posedge clk);
        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule